// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects 72 level-sensitive interrupt sources and presents them to a processor through a small word-addressed register window and a single interrupt request line. The sources are arranged as a group of 8 basic sources followed by two banks of 32. Each source has an enable bit. A source counts as pending while its input is high and its enable bit is set. The block keeps no latched copy of any source.

Software changes enables through two kinds of registers. One kind sets bits where a one is written. The other kind clears bits where a one is written. Reading either kind returns the current mask. A basic status word gathers the pending basic sources, one summary flag per bank, and shortcut copies of a fixed set of bank sources. With these shortcuts, the commonly used bank interrupts can be identified with one read.

The interrupt line is a registered OR of the basic status word. A register for fast-interrupt routing is present for software compatibility. It only holds the value written to it.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset all enable masks and the fast-interrupt register are zero, every readable offset returns zero, and `irq_out` is low.
- R2: Writing offset 0x10 (bank 1), 0x14 (bank 2) or 0x18 (basic, bits 7:0) sets each enable bit written as one and leaves bits written as zero unchanged; the new mask is in effect from the next clock edge.
- R3: Writing offset 0x1C (bank 1), 0x20 (bank 2) or 0x24 (basic) clears each enable bit written as one and leaves bits written as zero unchanged.
- R4: Reading a set offset or its matching clear offset returns that group's current enable mask, zero-extended to 32 bits.
- R5: Offset 0x04 reads bank 1 and offset 0x08 reads bank 2. Each bit is the source input ANDed with its enable bit, and the shortcut sources are included. Bank 1 bit n is source 8+n, and bank 2 bit n is source 40+n.
- R6: Bits 7:0 of the basic status word at offset 0x00 are the enabled, asserted basic sources 0 to 7.
- R7: Basic status bit 8 is high when any enabled, asserted bank 1 source other than bits 7, 9, 10, 18 and 19 is pending. Bit 9 is high under the same rule for bank 2, with bits 21 to 25 and 30 excluded.
- R8: Basic status bits 10 to 14 copy pending bank 1 bits 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy pending bank 2 bits 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 are zero.
- R9: `irq_out` equals the OR of all bits of the basic status word as it was one clock earlier.
- R10: Writes to the status offsets 0x00, 0x04 and 0x08 and to unmapped offsets change no enable bit. Unmapped offsets read zero.
- R11: Offset 0x0C stores and returns a full 32-bit value. That value has no effect on `irq_out` or on any status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_src | input | 72 | Source levels: 7:0 basic, 39:8 bank 1, 71:40 bank 2 |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Directed patterns drive one source at a time. A single shortcut source must raise only its shortcut bit and leave the bank summary low. A non-shortcut neighbour must raise only the summary. Together these show whether the shortcut positions and the summary exclusion mask are wired correctly. Other directed cases show that set and clear act only on bits written as one, and that writes to status, unmapped or fast-interrupt offsets leave the masks and the interrupt line unchanged. Random source levels mixed with random set and clear writes then compare all three status words, the masks and the interrupt line against a model in the bench after every step.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // register offsets (bytes)
    localparam int OFS_PEND_BASIC = 'h00;
    localparam int OFS_PEND_B1    = 'h04;
    localparam int OFS_PEND_B2    = 'h08;
    localparam int OFS_FIQ        = 'h0C;
    localparam int OFS_SET_B1     = 'h10;
    localparam int OFS_SET_B2     = 'h14;
    localparam int OFS_SET_BASIC  = 'h18;
    localparam int OFS_CLR_B1     = 'h1C;
    localparam int OFS_CLR_B2     = 'h20;
    localparam int OFS_CLR_BASIC  = 'h24;

    // shortcut sources, entry i at [i*5 +: 5], lowest status bit first
    localparam int SC1_N = 5;
    localparam int SC2_N = 6;
    localparam logic [SC1_N*5-1:0] SC1_LIST = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
    localparam logic [SC2_N*5-1:0] SC2_LIST = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};

    function automatic logic [31:0] list_mask5(input logic [29:0] list, input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[list[i*5 +: 5]] = 1'b1;
        return m;
    endfunction

    localparam logic [31:0] SC1_MASK = list_mask5(30'(SC1_LIST), SC1_N);
    localparam logic [31:0] SC2_MASK = list_mask5(30'(SC2_LIST), SC2_N);
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (set_we)
            mask <= mask | wdata;
        else if (clr_we)
            mask <= mask & ~wdata;
    end

    // R2: every bit written as one is set afterwards
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(wdata)) == $past(wdata)));
    // R2: bits written as zero keep their value
    a_r2_zero_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (((mask ^ $past(mask)) & ~$past(wdata)) == '0));
    // R3: every bit written as one is cleared afterwards
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));
    // R10: without a matching write the mask holds
    a_r10_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask));
endmodule

// File: rtl/irqc_pend_compose.sv
module irqc_pend_compose
    import irqc_pkg::*;
#(
    parameter int BASIC_N = 8,
    parameter int BANK_W  = 32,
    parameter int WORD_W  = 32
) (
    input  logic [BASIC_N-1:0] src_basic,
    input  logic [BASIC_N-1:0] en_basic,
    input  logic [BANK_W-1:0]  src_b1,
    input  logic [BANK_W-1:0]  en_b1,
    input  logic [BANK_W-1:0]  src_b2,
    input  logic [BANK_W-1:0]  en_b2,
    output logic [BANK_W-1:0]  pend_b1,
    output logic [BANK_W-1:0]  pend_b2,
    output logic [WORD_W-1:0]  pend_basic
);
    localparam int SUM1_POS = BASIC_N;
    localparam int SUM2_POS = BASIC_N + 1;
    localparam int SC1_POS  = BASIC_N + 2;
    localparam int SC2_POS  = SC1_POS + SC1_N;

    logic [SC1_N-1:0] sc1_bits;
    logic [SC2_N-1:0] sc2_bits;

    assign pend_b1 = src_b1 & en_b1;
    assign pend_b2 = src_b2 & en_b2;

    for (genvar i = 0; i < SC1_N; i++) begin : g_sc1
        assign sc1_bits[i] = pend_b1[SC1_LIST[i*5 +: 5]];
    end
    for (genvar j = 0; j < SC2_N; j++) begin : g_sc2
        assign sc2_bits[j] = pend_b2[SC2_LIST[j*5 +: 5]];
    end

    always_comb begin
        pend_basic                    = '0;
        pend_basic[BASIC_N-1:0]       = src_basic & en_basic;
        pend_basic[SUM1_POS]          = |(pend_b1 & ~SC1_MASK[BANK_W-1:0]);
        pend_basic[SUM2_POS]          = |(pend_b2 & ~SC2_MASK[BANK_W-1:0]);
        pend_basic[SC1_POS +: SC1_N]  = sc1_bits;
        pend_basic[SC2_POS +: SC2_N]  = sc2_bits;
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int BASIC_N = 8,
    parameter int BANK_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_we,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [BASIC_N+2*BANK_W-1:0]   irq_src,
    output logic                          irq_out
);
    localparam int B1_LO = BASIC_N;
    localparam int B2_LO = BASIC_N + BANK_W;

    logic [BASIC_N-1:0] en_basic;
    logic [BANK_W-1:0]  en_b1, en_b2, pend_b1, pend_b2;
    logic [DATA_W-1:0]  pend_basic;
    logic [DATA_W-1:0]  fiq_q;
    logic               irq_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    irqc_mask_reg #(.W(BASIC_N)) u_en_basic (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_we && hit(reg_addr, OFS_SET_BASIC)),
        .clr_we(reg_we && hit(reg_addr, OFS_CLR_BASIC)),
        .wdata(reg_wdata[BASIC_N-1:0]), .mask(en_basic));

    irqc_mask_reg #(.W(BANK_W)) u_en_b1 (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_we && hit(reg_addr, OFS_SET_B1)),
        .clr_we(reg_we && hit(reg_addr, OFS_CLR_B1)),
        .wdata(reg_wdata[BANK_W-1:0]), .mask(en_b1));

    irqc_mask_reg #(.W(BANK_W)) u_en_b2 (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_we && hit(reg_addr, OFS_SET_B2)),
        .clr_we(reg_we && hit(reg_addr, OFS_CLR_B2)),
        .wdata(reg_wdata[BANK_W-1:0]), .mask(en_b2));

    irqc_pend_compose #(.BASIC_N(BASIC_N), .BANK_W(BANK_W), .WORD_W(DATA_W)) u_compose (
        .src_basic(irq_src[BASIC_N-1:0]), .en_basic(en_basic),
        .src_b1(irq_src[B1_LO +: BANK_W]), .en_b1(en_b1),
        .src_b2(irq_src[B2_LO +: BANK_W]), .en_b2(en_b2),
        .pend_b1(pend_b1), .pend_b2(pend_b2), .pend_basic(pend_basic));

    // fast-interrupt routing word: stored only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fiq_q <= '0;
        else if (reg_we && hit(reg_addr, OFS_FIQ))
            fiq_q <= reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pend_basic;
    end
    assign irq_out = irq_q;

    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, OFS_PEND_BASIC))                                  reg_rdata = pend_basic;
        else if (hit(reg_addr, OFS_PEND_B1))                                reg_rdata = DATA_W'(pend_b1);
        else if (hit(reg_addr, OFS_PEND_B2))                                reg_rdata = DATA_W'(pend_b2);
        else if (hit(reg_addr, OFS_FIQ))                                    reg_rdata = fiq_q;
        else if (hit(reg_addr, OFS_SET_B1) || hit(reg_addr, OFS_CLR_B1))       reg_rdata = DATA_W'(en_b1);
        else if (hit(reg_addr, OFS_SET_B2) || hit(reg_addr, OFS_CLR_B2))       reg_rdata = DATA_W'(en_b2);
        else if (hit(reg_addr, OFS_SET_BASIC) || hit(reg_addr, OFS_CLR_BASIC)) reg_rdata = DATA_W'(en_basic);
    end

    // R9: request line is the previous cycle's OR of the basic word
    a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|pend_basic)));
    // R7: a bank summary flag needs a pending source in that bank
    a_r7_sum1_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        pend_basic[BASIC_N] |-> (pend_b1 != '0));
    a_r7_sum2_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        pend_basic[BASIC_N+1] |-> (pend_b2 != '0));
    // R5: nothing shows pending in a bank whose mask is empty
    a_r5_masked_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_b1 == '0) |-> (pend_b1 == '0));
endmodule

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [71:0] irq_src = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;

    logic [7:0]  m_basic = '0;
    logic [31:0] m_b1 = '0, m_b2 = '0, m_fiq = '0;

    always #5 clk = ~clk;

    irq_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src), .irq_out(irq_out));

    function automatic logic [31:0] exp_p1(logic [71:0] s, logic [31:0] e);
        return s[39:8] & e;
    endfunction
    function automatic logic [31:0] exp_p2(logic [71:0] s, logic [31:0] e);
        return s[71:40] & e;
    endfunction
    function automatic logic [31:0] exp_basic(logic [71:0] s, logic [7:0] eb,
                                              logic [31:0] e1, logic [31:0] e2);
        logic [31:0] w, p1, p2;
        p1 = exp_p1(s, e1);
        p2 = exp_p2(s, e2);
        w = '0;
        w[7:0] = s[7:0] & eb;
        w[8]   = |(p1 & ~32'h000C0680);
        w[9]   = |(p2 & ~32'h43E00000);
        w[10] = p1[7];  w[11] = p1[9];  w[12] = p1[10]; w[13] = p1[18]; w[14] = p1[19];
        w[15] = p2[21]; w[16] = p2[22]; w[17] = p2[23]; w[18] = p2[24]; w[19] = p2[25];
        w[20] = p2[30];
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic bus_wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            6'h10: m_b1 = m_b1 | d;
            6'h14: m_b2 = m_b2 | d;
            6'h18: m_basic = m_basic | d[7:0];
            6'h1C: m_b1 = m_b1 & ~d;
            6'h20: m_b2 = m_b2 & ~d;
            6'h24: m_basic = m_basic & ~d[7:0];
            6'h0C: m_fiq = d;
            default: ;
        endcase
    endtask

    // let one edge pass with stable inputs, then check everything
    task automatic settle_and_check(string tag);
        logic [31:0] wb;
        @(posedge clk); #1;
        wb = exp_basic(irq_src, m_basic, m_b1, m_b2);
        check({tag, " R9 irq"}, {31'b0, irq_out}, {31'b0, |wb});
        rd_chk(6'h00, wb, {tag, " R6 R7 R8 basic"});
        rd_chk(6'h04, exp_p1(irq_src, m_b1), {tag, " R5 bank1"});
        rd_chk(6'h08, exp_p2(irq_src, m_b2), {tag, " R5 bank2"});
        rd_chk(6'h10, m_b1, {tag, " R4 en1"});
        rd_chk(6'h20, m_b2, {tag, " R4 en2"});
        rd_chk(6'h24, {24'b0, m_basic}, {tag, " R4 enb"});
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        for (int a = 0; a < 11; a++) rd_chk(6'(a*4), 32'h0, "R1 read after reset");

        // R2 / R4 set semantics, zero bits untouched
        bus_wr(6'h10, 32'h0000_00F0);
        rd_chk(6'h1C, 32'h0000_00F0, "R4 clear offset reads mask");
        bus_wr(6'h10, 32'h0000_0F00);
        rd_chk(6'h10, 32'h0000_0FF0, "R2 set keeps zero bits");
        // R3 clear semantics
        bus_wr(6'h1C, 32'h0000_0030);
        rd_chk(6'h10, 32'h0000_0FC0, "R3 clear only written ones");
        // R10 writes to status / unmapped offsets ignored
        bus_wr(6'h04, 32'hFFFF_FFFF);
        bus_wr(6'h00, 32'hFFFF_FFFF);
        bus_wr(6'h28, 32'hFFFF_FFFF);
        rd_chk(6'h10, 32'h0000_0FC0, "R10 bank1 mask after status writes");
        rd_chk(6'h18, 32'h0, "R10 basic mask after status writes");
        rd_chk(6'h28, 32'h0, "R10 unmapped reads zero");
        bus_wr(6'h1C, 32'hFFFF_FFFF);

        // R11 fast-interrupt word stored, no effect
        irq_src = '1;
        bus_wr(6'h0C, 32'hA5C3_0F8E);
        rd_chk(6'h0C, 32'hA5C3_0F8E, "R11 readback");
        @(posedge clk); #1;
        check("R11 irq stays low", {31'b0, irq_out}, 32'h0);
        rd_chk(6'h00, 32'h0, "R11 basic word unaffected");

        // R8 / R7 shortcut versus summary
        bus_wr(6'h10, 32'hFFFF_FFFF);
        bus_wr(6'h14, 32'hFFFF_FFFF);
        irq_src = '0; irq_src[8+7] = 1'b1;
        settle_and_check("shortcut b1[7]");
        rd_chk(6'h00, 32'h0000_0400, "R8 only bit10 for bank1 bit7");
        irq_src = '0; irq_src[8+0] = 1'b1;
        settle_and_check("summary b1[0]");
        rd_chk(6'h00, 32'h0000_0100, "R7 only bit8 for bank1 bit0");
        irq_src = '0; irq_src[40+30] = 1'b1;
        settle_and_check("shortcut b2[30]");
        rd_chk(6'h00, 32'h0010_0000, "R8 only bit20 for bank2 bit30");
        irq_src = '0; irq_src[40+31] = 1'b1;
        settle_and_check("summary b2[31]");
        rd_chk(6'h00, 32'h0000_0200, "R7 only bit9 for bank2 bit31");
        bus_wr(6'h18, 32'h0000_0081);
        irq_src = '0; irq_src[7] = 1'b1; irq_src[1] = 1'b1;
        settle_and_check("basic");
        rd_chk(6'h00, 32'h0000_0080, "R6 enabled basic only");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [5:0] a;
            logic [31:0] d;
            int k;
            k = $urandom_range(0, 7);
            case (k)
                0: a = 6'h10; 1: a = 6'h14; 2: a = 6'h18; 3: a = 6'h1C;
                4: a = 6'h20; 5: a = 6'h24; 6: a = 6'h08; default: a = 6'h0C;
            endcase
            d = $urandom;
            if ($urandom_range(0, 3) == 0) d = d & $urandom;
            bus_wr(a, d);
            irq_src = {$urandom, $urandom, $urandom};
            if ($urandom_range(0, 4) == 0) irq_src = '0;
            settle_and_check("random");
            if (it % 50 == 0) rd_chk(6'h0C, m_fiq, "R11 random readback");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule